// File: doc/BRIEF.md
# Single-Bus Instruction Cycle Sequencer

This block is the control and register core of a small accumulator machine in which every register exchange goes over one shared internal bus. A beat counter steps the machine through four kinds of machine cycle: fetch, indirect-address, execute and interrupt. Each beat raises a set of bus-source enables and a set of bus-load enables. At most one source drives the bus in any beat, while any number of registers may capture from it. The core holds the program counter, memory address and memory data registers, instruction register, accumulator, stack pointer, and the two ALU staging registers: Y for an operand and Z for the result.

Main memory sits outside the block behind a plain synchronous port. The address comes from the memory address register, and the write data comes from the memory data register. Read data is valid exactly one cycle after a read strobe. There is no handshake and no back-pressure, so memory must always answer within that fixed latency. A single interrupt request line is honoured only when the interrupt-enable flag is set. When it is honoured, the current program counter is pushed to a descending stack and execution continues at a fixed vector.

Top module: `sbs_seq`

## Requirements
- R1: While reset is low, `pc_o`, `acc_o` and `ie_o` are 0, `cycle_o` is 0, and neither memory strobe is asserted. `cycle_o` encodes the cycle type as 0 fetch, 1 indirect, 2 execute, 3 interrupt.
- R2: At most one bit of `bus_drv` is set in any beat. The bits of `bus_drv` are: 0 program counter, 1 memory data register, 2 instruction address field (zero-extended), 3 accumulator, 4 Z, 5 stack pointer, 6 interrupt vector constant. The bits of `bus_ld` are: 0 memory address register, 1 memory data register, 2 instruction register, 3 accumulator, 4 Y, 5 Z (captures the ALU sum), 6 program counter.
- R3: Fetch takes five beats. Beat 1 drives the PC and loads the address register. Beat 2 reads at the PC. Beat 3 captures memory into the data register. Beat 4 drives the data register and loads the instruction register. Beat 5 adds one to the PC. The PC changes only by +1 or by a load of the vector.
- R4: An instruction word has opcode in bits 15:12, the indirect flag in bit 11 and the address in bits 10:0. Opcode 1 is load, 2 is add, 3 is interrupt-enable, and every other opcode is a one-beat no-operation.
- R5: When bit 11 is set, an indirect cycle of three beats follows fetch. It drives the address field into the address register, reads at that address, and captures the word into the data register. The execute cycle then takes its effective address from the data register rather than from the address field.
- R6: Add executes in six beats. The steps are: effective address to the address register; read; capture; data register to Y; accumulator on the bus with the sum into Z; Z to the accumulator. The accumulator ends as its old value plus the operand, modulo 2^16.
- R7: Load executes in four beats: effective address to the address register, read, capture, then data register to the accumulator.
- R8: Z is loaded only in a beat where the accumulator alone drives the bus, and only in the beat right after Y was loaded.
- R9: The interrupt request is sampled only in the last beat of an execute cycle, and only if `ie_o` is set in that beat. Otherwise the next cycle is fetch.
- R10: The interrupt cycle takes five beats. The steps are: stack pointer decremented; stack pointer to the address register; PC to the data register; memory write of the PC at the decremented stack address; vector to the PC. `mem_wr` is asserted in no other beat.
- R11: Entering the interrupt cycle clears `ie_o`. The interrupt-enable opcode sets it at the end of its execute beat, so the earliest instruction whose end can take an interrupt is the one that follows.
- R12: The data register captures `mem_rdata` in exactly the cycle after `mem_rd`, and neither strobe is asserted in that capture cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq | input | 1 | Interrupt request level |
| mem_addr | output | 11 | Memory address (address register) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data (data register) |
| mem_rdata | input | 16 | Memory read data, valid one cycle after `mem_rd` |
| bus_drv | output | 7 | Bus source enables for this beat |
| bus_ld | output | 7 | Bus load enables for this beat |
| bus_o | output | 16 | Value on the internal bus |
| cycle_o | output | 2 | Current machine cycle type |
| acc_o | output | 16 | Accumulator |
| pc_o | output | 16 | Program counter |
| ie_o | output | 1 | Interrupt-enable flag |

## Verification
The hardest situation to reach from the ports is an interrupt request arriving at the end of an execute cycle in which the enable flag has only just changed. That includes the instruction that sets it and the service routine that re-enables it while the request is still pending. The stimulus raises the request straight after reset and holds it high through several instructions while the flag is clear. It then runs an interrupt-enable instruction, which must not be interrupted itself. Inside the service routine it enables interrupts again, so the core re-enters the interrupt cycle and pushes a second return address below the first. Indirect load and indirect add are mixed into the program. The memory model returns a sentinel word on every cycle that is not a read reply, so any capture at the wrong time corrupts the accumulator.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  typedef enum logic [1:0] {
    CY_FETCH = 2'd0,
    CY_IND   = 2'd1,
    CY_EXEC  = 2'd2,
    CY_INTR  = 2'd3
  } cyc_e;

  // bus sources
  localparam int NSRC    = 7;
  localparam int SRC_PC  = 0;
  localparam int SRC_MDR = 1;
  localparam int SRC_IR  = 2;
  localparam int SRC_ACC = 3;
  localparam int SRC_Z   = 4;
  localparam int SRC_SP  = 5;
  localparam int SRC_VEC = 6;

  // bus loaders
  localparam int NDST    = 7;
  localparam int DST_MAR = 0;
  localparam int DST_MDR = 1;
  localparam int DST_IR  = 2;
  localparam int DST_ACC = 3;
  localparam int DST_Y   = 4;
  localparam int DST_Z   = 5;
  localparam int DST_PC  = 6;

  localparam int OP_LOAD = 1;
  localparam int OP_ADD  = 2;
  localparam int OP_EI   = 3;

  typedef struct packed {
    logic [NSRC-1:0] drv;
    logic [NDST-1:0] ld;
    logic            mem_rd;
    logic            mem_wr;
    logic            mdr_cap;
    logic            pc_inc;
    logic            sp_dec;
  } ctl_t;

endpackage

// File: rtl/sbs_ctrl.sv
module sbs_ctrl import sbs_pkg::*; #(
  parameter int OPW   = 4,
  parameter int BEATW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           irq,
  input  logic [OPW-1:0] op,
  input  logic           ind,
  output ctl_t           ctl,
  output cyc_e           cyc,
  output logic           ie
);

  cyc_e             cyc_q, cyc_d;
  logic [BEATW-1:0] beat_q, beat_d;
  logic             last;
  logic             ie_q, ie_d;
  logic             is_load, is_add, is_ei, mem_op;

  assign is_load = (op == OPW'(OP_LOAD));
  assign is_add  = (op == OPW'(OP_ADD));
  assign is_ei   = (op == OPW'(OP_EI));
  assign mem_op  = is_load | is_add;

  // beat decode: one control word per beat
  always_comb begin
    ctl  = '0;
    last = 1'b0;
    unique case (cyc_q)
      CY_FETCH: begin
        case (beat_q)
          BEATW'(0): begin ctl.drv[SRC_PC] = 1'b1; ctl.ld[DST_MAR] = 1'b1; end
          BEATW'(1): ctl.mem_rd  = 1'b1;
          BEATW'(2): ctl.mdr_cap = 1'b1;
          BEATW'(3): begin ctl.drv[SRC_MDR] = 1'b1; ctl.ld[DST_IR] = 1'b1; end
          default:   begin ctl.pc_inc = 1'b1; last = 1'b1; end
        endcase
      end
      CY_IND: begin
        case (beat_q)
          BEATW'(0): begin ctl.drv[SRC_IR] = 1'b1; ctl.ld[DST_MAR] = 1'b1; end
          BEATW'(1): ctl.mem_rd = 1'b1;
          default:   begin ctl.mdr_cap = 1'b1; last = 1'b1; end
        endcase
      end
      CY_EXEC: begin
        if (mem_op) begin
          case (beat_q)
            BEATW'(0): begin
              ctl.drv[ind ? SRC_MDR : SRC_IR] = 1'b1;
              ctl.ld[DST_MAR] = 1'b1;
            end
            BEATW'(1): ctl.mem_rd  = 1'b1;
            BEATW'(2): ctl.mdr_cap = 1'b1;
            BEATW'(3): begin
              ctl.drv[SRC_MDR] = 1'b1;
              if (is_load) begin
                ctl.ld[DST_ACC] = 1'b1;
                last = 1'b1;
              end else begin
                ctl.ld[DST_Y] = 1'b1;
              end
            end
            BEATW'(4): begin ctl.drv[SRC_ACC] = 1'b1; ctl.ld[DST_Z] = 1'b1; end
            default:   begin
              ctl.drv[SRC_Z] = 1'b1; ctl.ld[DST_ACC] = 1'b1; last = 1'b1;
            end
          endcase
        end else begin
          last = 1'b1;
        end
      end
      CY_INTR: begin
        case (beat_q)
          BEATW'(0): ctl.sp_dec = 1'b1;
          BEATW'(1): begin ctl.drv[SRC_SP] = 1'b1; ctl.ld[DST_MAR] = 1'b1; end
          BEATW'(2): begin ctl.drv[SRC_PC] = 1'b1; ctl.ld[DST_MDR] = 1'b1; end
          BEATW'(3): ctl.mem_wr = 1'b1;
          default:   begin
            ctl.drv[SRC_VEC] = 1'b1; ctl.ld[DST_PC] = 1'b1; last = 1'b1;
          end
        endcase
      end
    endcase
  end

  // cycle sequencing
  always_comb begin
    cyc_d  = cyc_q;
    beat_d = beat_q + BEATW'(1);
    if (last) begin
      beat_d = '0;
      unique case (cyc_q)
        CY_FETCH: cyc_d = ind ? CY_IND : CY_EXEC;
        CY_IND:   cyc_d = CY_EXEC;
        CY_EXEC:  cyc_d = (ie_q && irq) ? CY_INTR : CY_FETCH;
        CY_INTR:  cyc_d = CY_FETCH;
      endcase
    end
  end

  always_comb begin
    ie_d = ie_q;
    if (cyc_q == CY_EXEC && is_ei) ie_d = 1'b1;
    if (cyc_q == CY_EXEC && cyc_d == CY_INTR) ie_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q  <= CY_FETCH;
      beat_q <= '0;
      ie_q   <= 1'b0;
    end else begin
      cyc_q  <= cyc_d;
      beat_q <= beat_d;
      ie_q   <= ie_d;
    end
  end

  assign cyc = cyc_q;
  assign ie  = ie_q;

endmodule

// File: rtl/sbs_alu.sv
module sbs_alu #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  output logic [DW-1:0] sum
);

  assign sum = opa + opb;

endmodule

// File: rtl/sbs_regs.sv
module sbs_regs import sbs_pkg::*; #(
  parameter int          DW      = 16,
  parameter int          AW      = 11,
  parameter int unsigned VEC     = 512,
  parameter int unsigned SP_INIT = 2047
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctl_t          ctl,
  input  logic [DW-1:0] alu_sum,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] bus,
  output logic [AW-1:0] mar,
  output logic [DW-1:0] mdr,
  output logic [DW-1:0] ir,
  output logic [DW-1:0] acc,
  output logic [DW-1:0] y,
  output logic [DW-1:0] pc
);

  logic [DW-1:0] z, sp;
  logic [DW-1:0] src    [NSRC];
  logic [DW-1:0] masked [NSRC];

  assign src[SRC_PC]  = pc;
  assign src[SRC_MDR] = mdr;
  assign src[SRC_IR]  = {{(DW-AW){1'b0}}, ir[AW-1:0]};
  assign src[SRC_ACC] = acc;
  assign src[SRC_Z]   = z;
  assign src[SRC_SP]  = sp;
  assign src[SRC_VEC] = DW'(VEC);

  // each source gated by its own enable, then merged onto the bus
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign masked[g] = src[g] & {DW{ctl.drv[g]}};
  end

  always_comb begin
    bus = '0;
    for (int i = 0; i < NSRC; i++) bus = bus | masked[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mar <= '0;
    else if (ctl.ld[DST_MAR]) mar <= bus[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               mdr <= '0;
    else if (ctl.mdr_cap)     mdr <= mem_rdata;
    else if (ctl.ld[DST_MDR]) mdr <= bus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ir <= '0;
    else if (ctl.ld[DST_IR]) ir <= bus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc <= '0;
    else if (ctl.ld[DST_ACC]) acc <= bus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) y <= '0;
    else if (ctl.ld[DST_Y]) y <= bus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) z <= '0;
    else if (ctl.ld[DST_Z]) z <= alu_sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pc <= '0;
    else if (ctl.ld[DST_PC]) pc <= bus;
    else if (ctl.pc_inc)     pc <= pc + DW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp <= DW'(SP_INIT);
    else if (ctl.sp_dec) sp <= sp - DW'(1);
  end

endmodule

// File: rtl/sbs_seq.sv
module sbs_seq import sbs_pkg::*; #(
  parameter int          AW      = 11,
  parameter int          OPW     = 4,
  parameter int          DW      = OPW + 1 + AW,
  parameter int unsigned VEC     = 512,
  parameter int unsigned SP_INIT = 2047
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            irq,
  output logic [AW-1:0]   mem_addr,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic [NSRC-1:0] bus_drv,
  output logic [NDST-1:0] bus_ld,
  output logic [DW-1:0]   bus_o,
  output logic [1:0]      cycle_o,
  output logic [DW-1:0]   acc_o,
  output logic [DW-1:0]   pc_o,
  output logic            ie_o
);

  localparam int BEATW = 3;

  ctl_t          ctl;
  cyc_e          cyc;
  logic          ie;
  logic [DW-1:0] bus, mdr, ir, acc, y, pc, alu_sum;
  logic [AW-1:0] mar;

  sbs_ctrl #(.OPW(OPW), .BEATW(BEATW)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .irq   (irq),
    .op    (ir[DW-1 -: OPW]),
    .ind   (ir[AW]),
    .ctl   (ctl),
    .cyc   (cyc),
    .ie    (ie)
  );

  sbs_regs #(.DW(DW), .AW(AW), .VEC(VEC), .SP_INIT(SP_INIT)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .alu_sum   (alu_sum),
    .mem_rdata (mem_rdata),
    .bus       (bus),
    .mar       (mar),
    .mdr       (mdr),
    .ir        (ir),
    .acc       (acc),
    .y         (y),
    .pc        (pc)
  );

  sbs_alu #(.DW(DW)) u_alu (
    .opa (y),
    .opb (bus),
    .sum (alu_sum)
  );

  assign mem_addr  = mar;
  assign mem_rd    = ctl.mem_rd;
  assign mem_wr    = ctl.mem_wr;
  assign mem_wdata = mdr;
  assign bus_drv   = ctl.drv;
  assign bus_ld    = ctl.ld;
  assign bus_o     = bus;
  assign cycle_o   = cyc;
  assign acc_o     = acc;
  assign pc_o      = pc;
  assign ie_o      = ie;

endmodule

// File: rtl/sbs_seq_chk.sv
module sbs_seq_chk import sbs_pkg::*; #(
  parameter int          DW  = 16,
  parameter int unsigned VEC = 512
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] bus_drv,
  input logic [NDST-1:0] bus_ld,
  input logic            mem_rd,
  input logic            mem_wr,
  input logic [1:0]      cycle_o,
  input logic            ie_o,
  input logic [DW-1:0]   pc_o
);

  a_r2_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_drv));

  a_r12_capture_gap: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (!mem_rd && !mem_wr));

  a_r10_write_in_intr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (cycle_o == 2'd3));

  a_r10_vector_load: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ld[DST_PC] |-> (bus_drv[SRC_VEC] && cycle_o == 2'd3));

  a_r11_ie_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_o == 2'd3 && $past(cycle_o) != 2'd3) |-> !ie_o);

  a_r8_z_from_acc: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ld[DST_Z] |-> (bus_drv == NSRC'(1 << SRC_ACC)));

  a_r8_y_before_z: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ld[DST_Z] |-> $past(bus_ld[DST_Y]));

  a_r3_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_o != $past(pc_o)) |-> (pc_o == $past(pc_o) + DW'(1) || pc_o == DW'(VEC)));

endmodule

bind sbs_seq sbs_seq_chk #(.DW(DW), .VEC(VEC)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bus_drv (bus_drv),
  .bus_ld  (bus_ld),
  .mem_rd  (mem_rd),
  .mem_wr  (mem_wr),
  .cycle_o (cycle_o),
  .ie_o    (ie_o),
  .pc_o    (pc_o)
);

// File: tb/sim_sbs_seq.sv
`timescale 1ns/1ps
module sim_sbs_seq;
  import sbs_pkg::*;

  localparam int AW = 11;
  localparam int DW = 16;
  localparam int VEC = 512;
  localparam int SPI = 2047;

  localparam logic [6:0] D_PC  = 7'(1 << SRC_PC);
  localparam logic [6:0] D_MDR = 7'(1 << SRC_MDR);
  localparam logic [6:0] D_IR  = 7'(1 << SRC_IR);
  localparam logic [6:0] D_ACC = 7'(1 << SRC_ACC);
  localparam logic [6:0] D_Z   = 7'(1 << SRC_Z);
  localparam logic [6:0] D_SP  = 7'(1 << SRC_SP);
  localparam logic [6:0] D_VEC = 7'(1 << SRC_VEC);
  localparam logic [6:0] L_MAR = 7'(1 << DST_MAR);
  localparam logic [6:0] L_MDR = 7'(1 << DST_MDR);
  localparam logic [6:0] L_IR  = 7'(1 << DST_IR);
  localparam logic [6:0] L_ACC = 7'(1 << DST_ACC);
  localparam logic [6:0] L_Y   = 7'(1 << DST_Y);
  localparam logic [6:0] L_Z   = 7'(1 << DST_Z);
  localparam logic [6:0] L_PC  = 7'(1 << DST_PC);

  logic clk = 1'b0;
  logic rst_n, irq;
  logic [AW-1:0] mem_addr;
  logic mem_rd, mem_wr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic [6:0] bus_drv, bus_ld;
  logic [DW-1:0] bus_o, acc_o, pc_o;
  logic [1:0] cycle_o;
  logic ie_o;

  always #4 clk = ~clk;

  sbs_seq u0 (
    .clk(clk), .rst_n(rst_n), .irq(irq),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .bus_drv(bus_drv), .bus_ld(bus_ld), .bus_o(bus_o),
    .cycle_o(cycle_o), .acc_o(acc_o), .pc_o(pc_o), .ie_o(ie_o)
  );

  // synchronous memory; sentinel on every non-reply cycle (R12)
  logic [DW-1:0] mem [0:2047];
  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
    else        mem_rdata <= 16'hDEAD;
  end

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  typedef struct packed {
    logic [6:0]  drv;
    logic [6:0]  ld;
    logic        rd;
    logic        wr;
    logic [10:0] addr;
    logic [15:0] wd;
    logic [1:0]  cyc;
    logic [15:0] pc;
    logic [15:0] acc;
    logic        ie;
  } beat_t;

  beat_t q[$];
  string tq[$];
  logic [15:0] m_pc, m_acc, m_sp, m_ins;
  logic [10:0] m_ea;
  logic m_ie, m_ie_last;
  int nxt;
  int n_int = 0;

  task automatic push(input logic [6:0] d, input logic [6:0] l, input logic rd,
                      input logic wr, input logic [10:0] a, input logic [15:0] wd,
                      input logic [1:0] c, input string t);
    beat_t b;
    b.drv = d; b.ld = l; b.rd = rd; b.wr = wr; b.addr = a; b.wd = wd;
    b.cyc = c; b.pc = m_pc; b.acc = m_acc; b.ie = m_ie;
    q.push_back(b);
    tq.push_back(t);
  endtask

  task automatic gen_fetch();  // R3
    m_ins = mem[m_pc[10:0]];
    push(D_PC, L_MAR, 0, 0, 0, 0, 2'd0, "R3");
    push(0, 0, 1, 0, m_pc[10:0], 0, 2'd0, "R3");
    push(0, 0, 0, 0, 0, 0, 2'd0, "R3/R12");
    push(D_MDR, L_IR, 0, 0, 0, 0, 2'd0, "R3");
    push(0, 0, 0, 0, 0, 0, 2'd0, "R3");
    m_pc = m_pc + 16'd1;
    m_ea = m_ins[10:0];
    nxt = m_ins[11] ? 1 : 2;
  endtask

  task automatic gen_ind();  // R5
    push(D_IR, L_MAR, 0, 0, 0, 0, 2'd1, "R5");
    push(0, 0, 1, 0, m_ins[10:0], 0, 2'd1, "R5");
    push(0, 0, 0, 0, 0, 0, 2'd1, "R5/R12");
    m_ea = mem[m_ins[10:0]][10:0];
    nxt = 2;
  endtask

  task automatic gen_exec();  // R4 R6 R7 R8
    logic [3:0] op;
    logic [15:0] v;
    op = m_ins[15:12];
    m_ie_last = m_ie;
    if (op == 4'd1 || op == 4'd2) begin
      string t;
      t = (op == 4'd1) ? "R7" : "R6";
      push(m_ins[11] ? D_MDR : D_IR, L_MAR, 0, 0, 0, 0, 2'd2, t);
      push(0, 0, 1, 0, m_ea, 0, 2'd2, t);
      push(0, 0, 0, 0, 0, 0, 2'd2, "R12");
      v = mem[m_ea];
      if (op == 4'd1) begin
        push(D_MDR, L_ACC, 0, 0, 0, 0, 2'd2, "R7");
        m_acc = v;
      end else begin
        push(D_MDR, L_Y, 0, 0, 0, 0, 2'd2, "R8");
        push(D_ACC, L_Z, 0, 0, 0, 0, 2'd2, "R8");
        push(D_Z, L_ACC, 0, 0, 0, 0, 2'd2, "R6");
        m_acc = m_acc + v;
      end
    end else begin
      push(0, 0, 0, 0, 0, 0, 2'd2, "R4");
      if (op == 4'd3) m_ie = 1'b1;  // R11 set
    end
  endtask

  task automatic gen_int();  // R10 R11
    n_int++;
    m_ie = 1'b0;
    push(0, 0, 0, 0, 0, 0, 2'd3, "R10");
    m_sp = m_sp - 16'd1;
    push(D_SP, L_MAR, 0, 0, 0, 0, 2'd3, "R10");
    push(D_PC, L_MDR, 0, 0, 0, 0, 2'd3, "R10");
    push(0, 0, 0, 1, m_sp[10:0], m_pc, 2'd3, "R10");
    push(D_VEC, L_PC, 0, 0, 0, 0, 2'd3, "R10");
    m_pc = 16'(VEC);
    nxt = 0;
  endtask

  initial begin
    beat_t r;
    string t;
    bit ok;
    m_pc = 0; m_acc = 0; m_ie = 0; m_ie_last = 0; m_sp = 16'(SPI); nxt = 0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (q.size() == 0) begin
        case (nxt)
          0: gen_fetch();
          1: gen_ind();
          2: gen_exec();
          default: gen_int();
        endcase
      end
      r = q.pop_front();
      t = tq.pop_front();
      check($onehot0(bus_drv), "R2", "bus drivers", 32'(bus_drv), 32'(r.drv));
      ok = (bus_drv == r.drv) && (bus_ld == r.ld) && (mem_rd == r.rd) &&
           (mem_wr == r.wr) && (cycle_o == r.cyc) && (pc_o == r.pc) &&
           (!(r.rd || r.wr) || mem_addr == r.addr) && (!r.wr || mem_wdata == r.wd);
      check(ok, t, "beat drv/ld/rd/wr/cyc", {bus_drv, bus_ld, mem_rd, mem_wr, cycle_o, pc_o[13:0]},
            {r.drv, r.ld, r.rd, r.wr, r.cyc, r.pc[13:0]});
      check(acc_o == r.acc, t, "accumulator", 32'(acc_o), 32'(r.acc));
      check(ie_o == r.ie, "R11", "interrupt enable", 32'(ie_o), 32'(r.ie));
      if (q.size() == 0 && r.cyc == 2'd2)
        nxt = (m_ie_last && irq) ? 3 : 0;  // R9 sampling point
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int falls;
    logic pie;
    rst_n = 1'b0;
    irq = 1'b0;
    for (int i = 0; i < 2048; i++) mem[i] = '0;
    mem[0]   = 16'h1064;                // LOAD 100
    mem[1]   = 16'h2065;                // ADD 101
    mem[2]   = {4'd2, 1'b1, 11'd102};   // ADD indirect via 102
    mem[3]   = {4'd1, 1'b1, 11'd104};   // LOAD indirect via 104
    mem[4]   = 16'h0000;                // no-op
    mem[5]   = 16'h3000;                // enable interrupts
    mem[6]   = 16'h2065;                // ADD 101
    mem[100] = 16'd5;
    mem[101] = 16'd7;
    mem[102] = 16'd103;
    mem[103] = 16'hFFF0;
    mem[104] = 16'd105;
    mem[105] = 16'h1234;
    mem[VEC]   = 16'h2065;              // ADD 101
    mem[VEC+1] = 16'h3000;              // re-enable
    mem[VEC+2] = 16'h0000;

    repeat (2) @(negedge clk);
    // R1 reset state
    check(pc_o == 0,  "R1", "pc in reset",  32'(pc_o),  0);
    check(acc_o == 0, "R1", "acc in reset", 32'(acc_o), 0);
    check(ie_o == 0,  "R1", "ie in reset",  32'(ie_o),  0);
    check(cycle_o == 0 && !mem_rd && !mem_wr, "R1", "cycle/strobes in reset",
          {29'd0, cycle_o, mem_rd | mem_wr}, 0);

    @(posedge clk); #2;
    rst_n = 1'b1;
    irq = 1'b1;                         // R9: held while ie is still clear
    falls = 0;
    pie = 1'b0;
    while (falls < 2) begin
      @(posedge clk); #2;
      if (pie && !ie_o) falls++;
      pie = ie_o;
    end
    irq = 1'b0;
    repeat (150) @(posedge clk);
    @(negedge clk);
    check(n_int == 2, "R9", "interrupts taken", 32'(n_int), 2);
    check(mem[SPI-1] == 16'd7, "R10", "first pushed pc", 32'(mem[SPI-1]), 7);
    check(mem[SPI-2] == 16'(VEC+3), "R10", "second pushed pc", 32'(mem[SPI-2]), VEC+3);
    check(acc_o == 16'h1249, "R6/R12", "final accumulator", 32'(acc_o), 32'h1249);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule